// File: doc/BRIEF.md
# Score-Based Memory Bus Arbiter

This block decides which of several per-core miss queues may drive the shared memory bus next. Each cycle it looks at the queues' non-empty flags and issues a registered one-hot grant to one of them. The choice depends on a small saturating score kept for every queue, not on rotation order. Serving a queue raises its score by a programmable step. Every cycle in which another queue is served lowers it by one. The lowest score wins. A queue that requests rarely therefore sinks to a low score and is served almost at once, even while other queues keep the bus saturated.

A free-running linear feedback shift register advances once per grant. Now and then it suppresses the score update for that grant. The small irregularity this adds breaks up lockstep patterns between cores that run identical code. The queues, the bus protocol and memory timing are outside this block.

Top module: `score_bus_arbiter`

## Requirements
- R1: Grants are registered. A request pattern presented in one cycle produces, after the next rising clock edge, a `gnt_o` with at most one bit set. `gnt_valid_o` is high exactly when a bit is set, and the set bit always belongs to a queue that was requesting.
- R2: In a cycle with no request bit set, no grant follows (`gnt_o` = 0, `gnt_valid_o` = 0), and every score and the shift register keep their values.
- R3: Among the requesting queues, the one with the lowest score is granted.
- R4: When several requesting queues share the lowest score, the one with the lowest index is granted. Bit i of `req_i` and `gnt_o` belongs to queue i.
- R5: On an applied update, the granted queue's score increases by `step_up_i` (0 to 3) and saturates at 15. It never wraps.
- R6: On an applied update, every other queue's score decreases by 1 and stops at 0. This includes queues that were not requesting.
- R7: A 16-bit shift register holds 0x0001 after reset and advances only on cycles that produce a grant. On each advance it shifts left and places in bit 0 the XOR of bits 15, 13, 12 and 10. If its low 10 bits are all zero when a grant is made, no score changes for that grant; the register still advances.
- R8: After reset all scores are 0, `gnt_o` is 0 and `gnt_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Non-empty flag of each queue |
| step_up_i | input | 2 | Amount added to the winner's score |
| gnt_o | output | 4 | Registered one-hot grant |
| gnt_valid_o | output | 1 | High when `gnt_o` carries a grant |

## Verification
The bench builds the arbiter with its default parameters: four queues, 4-bit scores, a 16-bit shift register and a 10-bit skip mask. With these values, ceiling saturation is reached after five consecutive wins at a step of 3, and the ties left after reset exercise the index order. A long mixed run with varying steps reaches several suppressed updates within a few thousand grants. The bench keeps an independent model of the scores and the shift register, so every grant in that run checks the score history, including the effect of each skipped update.

// File: rtl/sba_pkg.sv
package sba_pkg;

   // Per-queue update command produced by the top for each score cell.
   typedef struct packed {
      logic commit;   // apply an update this cycle
      logic won;      // this queue is the one being granted
   } sba_upd_t;

endpackage

// File: rtl/sba_skip_lfsr.sv
module sba_skip_lfsr #(
   parameter int unsigned           LFSR_W    = 16,
   parameter logic [LFSR_W-1:0]     TAPS      = 16'hB400,
   parameter logic [LFSR_W-1:0]     SEED      = 16'h0001,
   parameter int unsigned           SKIP_BITS = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic adv_i,
   output logic skip_o
);

   logic [LFSR_W-1:0] lfsr_q;
   logic              fb;

   if (SKIP_BITS > LFSR_W) begin : g_bad_skip
      $error("SKIP_BITS must not exceed LFSR_W");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("LFSR seed must be nonzero");
   end

   assign fb     = ^(lfsr_q & TAPS);
   assign skip_o = (lfsr_q[SKIP_BITS-1:0] == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lfsr_q <= SEED;
      else if (adv_i) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
   end

   // R7: register never reaches the lock-up state
   a_r7_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lfsr_q != '0);
   // R7, R2: register moves only when a grant is made
   a_r7_lfsr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(lfsr_q));

endmodule

// File: rtl/sba_score_cell.sv
module sba_score_cell
   import sba_pkg::*;
#(
   parameter int unsigned SCORE_W = 4,
   parameter int unsigned STEP_W  = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  sba_upd_t           upd_i,
   input  logic [STEP_W-1:0]  step_i,
   output logic [SCORE_W-1:0] score_o
);

   localparam int unsigned        SUM_W = SCORE_W + 1;
   localparam logic [SCORE_W-1:0] S_MAX = '1;

   logic [SCORE_W-1:0] score_q, up_val, dn_val, nxt;
   logic [SUM_W-1:0]   sum;

   always_comb begin
      sum    = {1'b0, score_q} + SUM_W'(step_i);
      up_val = sum[SCORE_W] ? S_MAX : sum[SCORE_W-1:0];
      dn_val = (score_q == '0) ? '0 : score_q - 1'b1;
      nxt    = upd_i.won ? up_val : dn_val;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           score_q <= '0;
      else if (upd_i.commit) score_q <= nxt;
   end

   assign score_o = score_q;

   // R5: winner's score never drops (no wrap past the ceiling)
   a_r5_no_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i.commit && upd_i.won) |=> score_q >= $past(score_q));
   // R6: loser's score never rises (no wrap below zero)
   a_r6_no_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i.commit && !upd_i.won) |=> score_q <= $past(score_q));
   // R2, R7: without a committed update the score is frozen
   a_r7_score_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_i.commit |=> $stable(score_q));

endmodule

// File: rtl/sba_min_select.sv
module sba_min_select #(
   parameter int unsigned NUM_REQ = 4,
   parameter int unsigned SCORE_W = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic [NUM_REQ-1:0]              req_i,
   input  logic [NUM_REQ-1:0][SCORE_W-1:0] scores_i,
   output logic [IDX_W-1:0]                win_idx_o,
   output logic [NUM_REQ-1:0]              win_oh_o,
   output logic                            any_o
);

   logic               found;
   logic [SCORE_W-1:0] best;
   logic [IDX_W-1:0]   idx;

   // Ascending scan with strict compare: equal scores keep the lower index.
   always_comb begin
      found = 1'b0;
      best  = '0;
      idx   = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (req_i[i] && (!found || scores_i[i] < best)) begin
            found = 1'b1;
            best  = scores_i[i];
            idx   = IDX_W'(i);
         end
      end
   end

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_oh
      assign win_oh_o[g] = found && (idx == IDX_W'(g));
   end

   assign win_idx_o = idx;
   assign any_o     = found;

endmodule

// File: rtl/score_bus_arbiter.sv
module score_bus_arbiter
   import sba_pkg::*;
#(
   parameter int unsigned       NUM_REQ   = 4,
   parameter int unsigned       SCORE_W   = 4,
   parameter int unsigned       LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'h0001,
   parameter int unsigned       SKIP_BITS = 10,
   localparam int unsigned      IDX_W     = (NUM_REQ > 2) ? $clog2(NUM_REQ) : 1,
   localparam int unsigned      STEP_W    = IDX_W
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_REQ-1:0]  req_i,
   input  logic [STEP_W-1:0]   step_up_i,
   output logic [NUM_REQ-1:0]  gnt_o,
   output logic                gnt_valid_o
);

   if (NUM_REQ < 2) begin : g_bad_n
      $error("NUM_REQ must be at least 2");
   end
   if (STEP_W > SCORE_W) begin : g_bad_w
      $error("SCORE_W too narrow for the step range");
   end

   logic [NUM_REQ-1:0][SCORE_W-1:0] scores;
   logic [IDX_W-1:0]                win_idx;
   logic [NUM_REQ-1:0]              win_oh;
   logic                            any_req, skip, commit;
   logic [NUM_REQ-1:0]              gnt_q;
   logic                            vld_q;

   sba_min_select #(
      .NUM_REQ (NUM_REQ),
      .SCORE_W (SCORE_W),
      .IDX_W   (IDX_W)
   ) u_sel (
      .req_i     (req_i),
      .scores_i  (scores),
      .win_idx_o (win_idx),
      .win_oh_o  (win_oh),
      .any_o     (any_req)
   );

   sba_skip_lfsr #(
      .LFSR_W    (LFSR_W),
      .TAPS      (LFSR_TAPS),
      .SEED      (LFSR_SEED),
      .SKIP_BITS (SKIP_BITS)
   ) u_skip (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (any_req),
      .skip_o (skip)
   );

   assign commit = any_req && !skip;

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_cell
      sba_upd_t upd;
      assign upd.commit = commit;
      assign upd.won    = win_oh[g];

      sba_score_cell #(
         .SCORE_W (SCORE_W),
         .STEP_W  (STEP_W)
      ) u_cell (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .upd_i   (upd),
         .step_i  (step_up_i),
         .score_o (scores[g])
      );

      // R3, R4: no requesting queue beats the chosen one
      a_r3_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (any_req && req_i[g] && win_idx != IDX_W'(g)) |->
            (scores[g] > scores[win_idx] ||
             (scores[g] == scores[win_idx] && IDX_W'(g) > win_idx)));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gnt_q <= '0;
         vld_q <= 1'b0;
      end else begin
         gnt_q <= win_oh;
         vld_q <= any_req;
      end
   end

   assign gnt_o       = gnt_q;
   assign gnt_valid_o = vld_q;

   // R1: at most one grant bit
   a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_o));
   // R1: valid flag agrees with the grant vector
   a_r1_valid_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_valid_o == (gnt_o != '0));
   // R1: a grant always goes to a queue that requested one cycle earlier
   a_r1_granted_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i != '0) |=> ((gnt_o & $past(req_i)) != '0));
   // R2: idle cycle yields no grant
   a_r2_idle_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i == '0) |=> !gnt_valid_o);

endmodule

// File: tb/score_bus_arbiter_tb.sv
module score_bus_arbiter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0;
   logic [1:0] stepu = '0;
   logic [3:0] gnt;
   logic       gvld;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // reference model state (from the requirements)
   int         m_score [4];
   logic [15:0] m_lfsr;
   int         m_skips = 0;
   logic [31:0] rng = 32'h1234_5678;

   always #4 clk = ~clk;   // 125 MHz

   score_bus_arbiter u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_i       (req),
      .step_up_i   (stepu),
      .gnt_o       (gnt),
      .gnt_valid_o (gvld)
   );

   task automatic chk(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual valid/gnt=%b expected=%b", tag, act, exp);
      end
   endtask

   // Drive one request pattern, advance the model, check the registered grant.
   task automatic cycle(input logic [3:0] rq, input logic [1:0] x, input string tag,
                        output logic [3:0] exp_g);
      int   win;
      logic fb;
      @(negedge clk);
      req   = rq;
      stepu = x;
      win   = -1;
      for (int i = 0; i < 4; i++)
         if (rq[i] && (win < 0 || m_score[i] < m_score[win])) win = i;
      exp_g = (win < 0) ? 4'b0000 : 4'(1 << win);
      if (win >= 0) begin
         if (m_lfsr[9:0] == 10'd0) m_skips++;
         else begin
            for (int i = 0; i < 4; i++) begin
               if (i == win) m_score[i] = (m_score[i] + x > 15) ? 15 : m_score[i] + x;
               else          m_score[i] = (m_score[i] == 0) ? 0 : m_score[i] - 1;
            end
         end
         fb     = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
         m_lfsr = {m_lfsr[14:0], fb};
      end
      @(posedge clk);
      #1;
      chk({gvld, gnt} == {(win >= 0), exp_g}, tag, {gvld, gnt}, {(win >= 0), exp_g});
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      req = '0;
      for (int i = 0; i < 4; i++) m_score[i] = 0;
      m_lfsr = 16'h0001;
      repeat (3) @(posedge clk);
      #1;
      chk({gvld, gnt} == 5'b0, "R8 reset outputs", {gvld, gnt}, 5'b0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_idle;
      logic [3:0] e;
      for (int k = 0; k < 4; k++) cycle(4'b0000, 2'd3, "R2 idle no grant", e);
   endtask

   task automatic t_tie;
      logic [3:0] e;
      cycle(4'b1111, 2'd3, "R4 tie after reset", e);
      chk(gnt == 4'b0001, "R4 lowest index on tie", {gvld, gnt}, 5'b10001);
      cycle(4'b1111, 2'd3, "R3 lowest score wins", e);
      chk(gnt == 4'b0010, "R3 served queue loses priority", {gvld, gnt}, 5'b10010);
      cycle(4'b1100, 2'd3, "R4 tie upper pair", e);
   endtask

   task automatic t_idle_hold;
      logic [3:0] e;
      // scores must be unchanged across idle cycles: ordering afterwards shows it
      for (int k = 0; k < 5; k++) cycle(4'b0000, 2'd1, "R2 idle holds", e);
      cycle(4'b1111, 2'd1, "R2 order preserved after idle", e);
   endtask

   task automatic t_flood;
      logic [3:0] e;
      for (int k = 0; k < 12; k++) cycle(4'b0111, 2'd3, "R3 flood", e);
      cycle(4'b1111, 2'd3, "R3 rare requester served", e);
      chk(gnt == 4'b1000, "R3 rare queue first", {gvld, gnt}, 5'b11000);
   endtask

   task automatic t_saturate;
      logic [3:0] e;
      for (int k = 0; k < 8; k++) cycle(4'b0001, 2'd3, "R5 climb to ceiling", e);
      for (int k = 0; k < 2; k++) cycle(4'b0011, 2'd0, "R5 R6 saturated contest", e);
      for (int k = 0; k < 20; k++) cycle(4'b0010, 2'd0, "R6 floor at zero", e);
      cycle(4'b0011, 2'd2, "R6 decayed ceiling", e);
   endtask

   task automatic t_zero_step;
      logic [3:0] e;
      for (int k = 0; k < 20; k++) cycle(4'b1000, 2'd0, "R6 drain", e);
      for (int k = 0; k < 6; k++) cycle(4'b1001, 2'd0, "R5 zero step keeps winner", e);
   endtask

   task automatic t_mixed;
      logic [3:0] e;
      int n = 0;
      while ((m_skips < 3 || n < 3000) && n < 40000) begin
         rng = rng ^ (rng << 13);
         rng = rng ^ (rng >> 17);
         rng = rng ^ (rng << 5);
         cycle(rng[3:0] & rng[7:4] | rng[11:8] & {3'b000, rng[12]},
               rng[17:16], "R7 R3 mixed run", e);
         n++;
      end
      chk(m_skips >= 3, "R7 skipped updates reached", 5'(m_skips), 5'd3);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_tie();
      t_idle_hold();
      t_flood();
      t_saturate();
      t_zero_step();
      t_mixed();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule